// File: doc/BRIEF.md
# Counting Semaphore Cell

This block is one storage cell of an inter-thread synchronisation unit, configured as a counting semaphore. It holds a 16-bit count and exposes it through a single request port. Each request carries a view code that selects how the access is interpreted. A read in one of the two semaphore views is a take: it returns the count held before the access and lowers it by one. A write in either semaphore view is a give: it raises the count by one, saturating at the top, and ignores the write data. The other views give a raw look at the count, a tag word with status bits, or nothing useful. In each of those views this cell behaves as a non-queue cell.

A take in the blocking semaphore view that finds the count at zero is refused. The response is flagged as a stall so that the requester can retry later, and the requester's ID is recorded in a waiter vector. The next give sends a one-cycle wake pulse that carries the whole waiter vector, then empties it. A take in the non-blocking view that finds zero simply returns zero. Thread scheduling and address decoding sit outside the block. `DATA_W` must be at least 18 so that the tag word fits.

Top module: `sem_cell`

## Requirements
- R1: After reset, the count, the tag bits T, F and E, and the waiter vector are all zero. No response and no wake pulse is pending.
- R2: A read in view 4 (blocking take) or view 5 (non-blocking take) with a nonzero count returns the prior count and lowers the count by one.
- R3: A read in view 4 with a zero count returns data 0 with `rsp_stall` high. It leaves the count unchanged and sets bit `req_id` of the waiter vector.
- R4: A read in view 5 with a zero count returns 0 with no stall. It changes neither the count nor the waiter vector.
- R5: A write in view 4 or view 5 raises the count by one, holding at 0xFFFF when already there. The write data has no effect on the result.
- R6: A give with a nonempty waiter vector pulses `wake_valid` for one cycle, with `wake_mask` equal to the vector before the give, and leaves the vector empty. A give with no waiters raises no pulse.
- R7: A read in view 0 (raw) returns the count zero-extended and does not change it. A write in view 0 is ignored.
- R8: A read in view 1 (tag) returns E at bit 0, F at bit 1, T at bit 16, a queue-mode bit of 0 at bit 17, and zeros elsewhere. A write in view 1 loads E, F and T from those same bits, and bit 17 of the write is ignored.
- R9: Reads in view 2 or view 3 (queue views) return 0 without stalling. Writes in those views are ignored.
- R10: Reads in views 6 to 15 return all ones, and writes in those views are ignored.
- R11: Each read request produces exactly one response with `rsp_valid` high in the cycle after the request. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_view | input | 4 | View code selecting the access type |
| req_id | input | $clog2(NUM_REQ) | Requester ID, used when a take is refused |
| req_wdata | input | DATA_W | Write data (used only by tag writes) |
| rsp_valid | output | 1 | Read response valid |
| rsp_stall | output | 1 | Blocking take refused; requester must retry |
| rsp_data | output | DATA_W | Read response data |
| wake_valid | output | 1 | One-cycle wake pulse |
| wake_mask | output | NUM_REQ | Waiters released by the give |

## Verification
The hardest state to reach is the saturation point: the only way to raise the count is one give per cycle, and there is no load path. The stimulus therefore issues 65,534 back-to-back gives and then one extra give with junk data. Raw reads follow, along with a take that must step down from the top value. Wake behaviour is driven by refusing blocking takes from two different IDs before a give. A second give follows, and it must raise no pulse.

// File: rtl/sem_cell_pkg.sv
package sem_cell_pkg;

    localparam int VIEW_W = 4;

    // View codes; the numbering is fixed because the requester encodes it.
    typedef enum logic [VIEW_W-1:0] {
        VW_RAW    = 4'd0,
        VW_TAG    = 4'd1,
        VW_Q_BLK  = 4'd2,
        VW_Q_TRY  = 4'd3,
        VW_PV_BLK = 4'd4,
        VW_PV_TRY = 4'd5
    } view_e;

    // Tag-word bit positions seen by software.
    localparam int TAG_E_POS    = 0;
    localparam int TAG_F_POS    = 1;
    localparam int TAG_T_POS    = 16;
    localparam int TAG_QMODE_POS = 17;

    typedef struct packed {
        logic t;
        logic f;
        logic e;
    } tag_t;

    typedef struct packed {
        logic take;      // semaphore read, either variant
        logic take_blk;  // semaphore read, blocking variant
        logic give;      // semaphore write, either variant
        logic raw_rd;
        logic tag_rd;
        logic tag_wr;
        logic q_rd;
        logic bad_rd;
        logic any_rd;
    } op_t;

    function automatic op_t decode_op(input logic vld, input logic wr,
                                      input logic [VIEW_W-1:0] view);
        op_t o;
        logic rd;
        o  = '0;
        rd = vld && !wr;
        o.any_rd = rd;
        case (view_e'(view))
            VW_RAW:    o.raw_rd = rd;
            VW_TAG: begin
                o.tag_rd = rd;
                o.tag_wr = vld && wr;
            end
            VW_Q_BLK, VW_Q_TRY: o.q_rd = rd;
            VW_PV_BLK: begin
                o.take     = rd;
                o.take_blk = rd;
                o.give     = vld && wr;
            end
            VW_PV_TRY: begin
                o.take = rd;
                o.give = vld && wr;
            end
            default:   o.bad_rd = rd;
        endcase
        return o;
    endfunction

    function automatic logic [31:0] pack_tag(input tag_t tg);
        logic [31:0] w;
        w = '0;
        w[TAG_E_POS]     = tg.e;
        w[TAG_F_POS]     = tg.f;
        w[TAG_T_POS]     = tg.t;
        w[TAG_QMODE_POS] = 1'b0;
        return w;
    endfunction

endpackage

// File: rtl/sem_view_decode.sv
module sem_view_decode
    import sem_cell_pkg::*;
(
    input  logic              vld,
    input  logic              wr,
    input  logic [VIEW_W-1:0] view,
    output op_t               op
);
    always_comb op = decode_op(vld, wr, view);
endmodule

// File: rtl/sem_count_core.sv
module sem_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             give,
    output logic [CNT_W-1:0] cnt,
    output logic             is_zero
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             at_max;

    assign is_zero = (cnt_q == '0);
    assign at_max  = (cnt_q == CNT_MAX);
    assign cnt     = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (take && !is_zero) begin
            cnt_q <= cnt_q - CNT_ONE;
        end else if (give && !at_max) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end
endmodule

// File: rtl/sem_waiter_set.sv
module sem_waiter_set #(
    parameter int NUM_REQ = 8,
    parameter int ID_W    = $clog2(NUM_REQ)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               record,
    input  logic [ID_W-1:0]    rec_id,
    input  logic               release_all,
    output logic [NUM_REQ-1:0] waiters,
    output logic               wake_valid,
    output logic [NUM_REQ-1:0] wake_mask
);
    logic [NUM_REQ-1:0] wait_q;

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || release_all) begin
                wait_q[i] <= 1'b0;
            end else if (record && (rec_id == ID_W'(i))) begin
                wait_q[i] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_valid <= 1'b0;
            wake_mask  <= '0;
        end else begin
            wake_valid <= release_all && (wait_q != '0);
            wake_mask  <= release_all ? wait_q : '0;
        end
    end

    assign waiters = wait_q;
endmodule

// File: rtl/sem_tag_regs.sv
module sem_tag_regs
    import sem_cell_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output tag_t              tag
);
    tag_t tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '0;
        end else if (wr) begin
            tag_q.e <= wdata[TAG_E_POS];
            tag_q.f <= wdata[TAG_F_POS];
            tag_q.t <= wdata[TAG_T_POS];
        end
    end

    assign tag = tag_q;
endmodule

// File: rtl/sem_cell.sv
module sem_cell
    import sem_cell_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 16,
    parameter int NUM_REQ = 8,
    localparam int ID_W   = $clog2(NUM_REQ)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_wr,
    input  logic [VIEW_W-1:0]  req_view,
    input  logic [ID_W-1:0]    req_id,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic               rsp_stall,
    output logic [DATA_W-1:0]  rsp_data,
    output logic               wake_valid,
    output logic [NUM_REQ-1:0] wake_mask
);
    op_t                op;
    logic [CNT_W-1:0]   cnt_q;
    logic               cnt_zero;
    logic [NUM_REQ-1:0] waiters;
    tag_t               tag;
    logic               refuse;
    logic [DATA_W-1:0]  rd_word;
    logic [31:0]        tag_word;
    logic               unused_wdata;

    sem_view_decode u_dec (
        .vld  (req_valid),
        .wr   (req_wr),
        .view (req_view),
        .op   (op)
    );

    sem_count_core #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .take    (op.take),
        .give    (op.give),
        .cnt     (cnt_q),
        .is_zero (cnt_zero)
    );

    assign refuse = op.take_blk && cnt_zero;

    sem_waiter_set #(.NUM_REQ(NUM_REQ), .ID_W(ID_W)) u_wait (
        .clk         (clk),
        .rst         (rst),
        .record      (refuse),
        .rec_id      (req_id),
        .release_all (op.give),
        .waiters     (waiters),
        .wake_valid  (wake_valid),
        .wake_mask   (wake_mask)
    );

    sem_tag_regs #(.DATA_W(DATA_W)) u_tag (
        .clk   (clk),
        .rst   (rst),
        .wr    (op.tag_wr),
        .wdata (req_wdata),
        .tag   (tag)
    );

    assign tag_word     = pack_tag(tag);
    assign unused_wdata = ^req_wdata;

    always_comb begin
        rd_word = '0;
        if (op.raw_rd || op.take) begin
            rd_word = DATA_W'(cnt_q);
        end else if (op.tag_rd) begin
            rd_word = DATA_W'(tag_word);
        end else if (op.bad_rd) begin
            rd_word = '1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_stall <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= op.any_rd;
            rsp_stall <= refuse;
            rsp_data  <= op.any_rd ? rd_word : '0;
        end
    end
endmodule

// File: rtl/sem_cell_chk.sv
module sem_cell_chk #(
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 16,
    parameter int NUM_REQ = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_wr,
    input logic               rsp_valid,
    input logic               rsp_stall,
    input logic [DATA_W-1:0]  rsp_data,
    input logic               wake_valid,
    input logic [NUM_REQ-1:0] wake_mask,
    input logic [CNT_W-1:0]   cnt,
    input logic [NUM_REQ-1:0] waiters
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] TOPV = {CNT_W{1'b1}};

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && !req_wr)); // R11

    AST_READ_GETS_RSP: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_wr) |=> rsp_valid); // R11

    AST_STALL_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
        rsp_stall |-> (rsp_valid && rsp_data == '0)); // R3

    AST_STALL_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
        rsp_stall |-> $stable(cnt)); // R3

    AST_WAKE_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        wake_valid |-> (wake_mask != '0)); // R6

    AST_WAKE_CLEARS_SET: assert property (@(posedge clk) disable iff (rst)
        wake_valid |-> (waiters == '0)); // R6

    AST_COUNT_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(cnt) |-> ((cnt - $past(cnt)) == ONE || ($past(cnt) - cnt) == ONE)); // R5

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        ($past(cnt) == TOPV && cnt != TOPV) |-> $past(req_valid && !req_wr)); // R5
endmodule

bind sem_cell sem_cell_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .NUM_REQ(NUM_REQ)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_wr     (req_wr),
    .rsp_valid  (rsp_valid),
    .rsp_stall  (rsp_stall),
    .rsp_data   (rsp_data),
    .wake_valid (wake_valid),
    .wake_mask  (wake_mask),
    .cnt        (cnt_q),
    .waiters    (waiters)
);

// File: tb/sim_sem_cell.sv
module sim_sem_cell;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W  = 32;
    localparam int CNT_W   = 16;
    localparam int NUM_REQ = 8;
    localparam int ID_W    = 3;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               req_valid = 1'b0;
    logic               req_wr = 1'b0;
    logic [3:0]         req_view = '0;
    logic [ID_W-1:0]    req_id = '0;
    logic [DATA_W-1:0]  req_wdata = '0;
    logic               rsp_valid, rsp_stall, wake_valid;
    logic [DATA_W-1:0]  rsp_data;
    logic [NUM_REQ-1:0] wake_mask;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Scoreboard queues: {stall, data} expected responses and wake masks.
    logic [DATA_W:0]    exp_q[$];
    string              exp_tag[$];
    logic [NUM_REQ-1:0] wake_q[$];

    // Requirement model.
    logic [CNT_W-1:0]   m_cnt = '0;
    logic [NUM_REQ-1:0] m_wait = '0;
    logic               m_t = 1'b0, m_f = 1'b0, m_e = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sem_cell #(.DATA_W(DATA_W), .CNT_W(CNT_W), .NUM_REQ(NUM_REQ)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_wr(req_wr),
        .req_view(req_view), .req_id(req_id), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_stall(rsp_stall), .rsp_data(rsp_data),
        .wake_valid(wake_valid), .wake_mask(wake_mask)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: applies one request for one cycle and records what must follow.
    task automatic req(input logic wr, input logic [3:0] view, input logic [ID_W-1:0] id,
                       input logic [DATA_W-1:0] wd, input string tag);
        logic [DATA_W:0] e;
        req_valid = 1'b1; req_wr = wr; req_view = view; req_id = id; req_wdata = wd;
        e = '0;
        if (!wr) begin
            case (view)
                4'd0: e[DATA_W-1:0] = DATA_W'(m_cnt);
                4'd1: e[DATA_W-1:0] = (DATA_W'(m_t) << 16) | (DATA_W'(m_f) << 1) | DATA_W'(m_e);
                4'd2, 4'd3: e = '0;
                4'd4: begin
                    if (m_cnt != 0) begin e[DATA_W-1:0] = DATA_W'(m_cnt); m_cnt--; end
                    else begin e[DATA_W] = 1'b1; m_wait[id] = 1'b1; end
                end
                4'd5: if (m_cnt != 0) begin e[DATA_W-1:0] = DATA_W'(m_cnt); m_cnt--; end
                default: e[DATA_W-1:0] = '1;
            endcase
            exp_q.push_back(e);
            exp_tag.push_back(tag);
        end else begin
            if (view == 4'd1) begin
                m_t = wd[16]; m_f = wd[1]; m_e = wd[0];
            end else if (view == 4'd4 || view == 4'd5) begin
                if (m_cnt != '1) m_cnt++;
                if (m_wait != '0) begin wake_q.push_back(m_wait); m_wait = '0; end
            end
        end
        @(negedge clk);
        req_valid = 1'b0; req_wr = 1'b0;
    endtask

    // Monitor: compares outputs mid-cycle, after the registered update.
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    check("R11 unexpected response", 64'(rsp_valid), 64'd0);
                end else begin
                    logic [DATA_W:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = exp_tag.pop_front();
                    check({t, " data"}, 64'(rsp_data), 64'(e[DATA_W-1:0]));
                    check({t, " stall"}, 64'(rsp_stall), 64'(e[DATA_W]));
                end
            end
            if (wake_valid) begin
                if (wake_q.size() == 0) check("R6 unexpected wake", 64'(wake_mask), 64'd0);
                else check("R6 wake mask", 64'(wake_mask), 64'(wake_q.pop_front()));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R11 actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        check("R1 wake_valid after reset", 64'(wake_valid), 64'd0);
        req(1'b0, 4'd1, '0, '0, "R1 R8 tag word after reset");
        req(1'b0, 4'd0, '0, '0, "R1 raw count after reset");

        // Zero-count takes.
        req(1'b0, 4'd5, 3'd1, '0, "R4 try take at zero");
        req(1'b0, 4'd0, '0, '0, "R4 count unchanged");
        req(1'b0, 4'd4, 3'd2, '0, "R3 blocking take id2");
        req(1'b0, 4'd4, 3'd5, '0, "R3 blocking take id5");
        req(1'b0, 4'd0, '0, '0, "R3 count unchanged");

        // Gives: first wakes ids 2 and 5, second wakes nobody.
        req(1'b1, 4'd4, '0, 32'hDEAD_BEEF, "R6 give wakes");
        req(1'b1, 4'd5, '0, 32'h0000_0007, "R6 give no waiters");
        req(1'b0, 4'd0, '0, '0, "R5 count after two gives");

        // Successful takes.
        req(1'b0, 4'd4, 3'd0, '0, "R2 blocking take");
        req(1'b0, 4'd5, 3'd0, '0, "R2 try take");
        req(1'b0, 4'd0, '0, '0, "R2 count after takes");
        req(1'b1, 4'd4, '0, '0, "R2 give");
        req(1'b0, 4'd4, 3'd3, '0, "R2 blocking take of one");

        // Ignored views.
        req(1'b1, 4'd0, '0, 32'h0000_1234, "R7 raw write");
        req(1'b0, 4'd0, '0, '0, "R7 raw write ignored");
        req(1'b1, 4'd2, '0, 32'h0000_0055, "R9 queue write");
        req(1'b1, 4'd3, '0, 32'h0000_0066, "R9 queue write");
        req(1'b0, 4'd2, 3'd4, '0, "R9 queue read blocking view");
        req(1'b0, 4'd3, 3'd4, '0, "R9 queue read try view");
        req(1'b0, 4'd0, '0, '0, "R9 count unchanged");
        req(1'b0, 4'd7, '0, '0, "R10 undefined view read");
        req(1'b0, 4'd15, '0, '0, "R10 top view read");
        req(1'b1, 4'd9, '0, 32'hFFFF_FFFF, "R10 undefined view write");
        req(1'b0, 4'd0, '0, '0, "R10 count unchanged");

        // Tag view.
        req(1'b1, 4'd1, '0, 32'h0003_0003, "R8 tag write");
        req(1'b0, 4'd1, '0, '0, "R8 tag read set");
        req(1'b0, 4'd0, '0, '0, "R8 count unchanged");
        req(1'b1, 4'd1, '0, 32'h0000_0002, "R8 tag write F only");
        req(1'b0, 4'd1, '0, '0, "R8 tag read F");

        // Single waiter, then climb to saturation.
        req(1'b0, 4'd4, 3'd7, '0, "R3 blocking take id7");
        req(1'b1, 4'd5, '0, 32'hA5A5_A5A5, "R6 give wakes id7");
        for (int i = 0; i < 65534; i++) req(1'b1, 4'd4, '0, 32'(i), "R5 climb");
        req(1'b0, 4'd0, '0, '0, "R5 count at top");
        req(1'b1, 4'd5, '0, 32'h1234_5678, "R5 saturating give");
        req(1'b0, 4'd0, '0, '0, "R5 count held at top");
        req(1'b0, 4'd5, 3'd0, '0, "R5 take from top");
        req(1'b0, 4'd0, '0, '0, "R5 count below top");

        repeat (3) @(negedge clk);
        check("R11 responses drained", 64'(exp_q.size()), 64'd0);
        check("R6 wakes drained", 64'(wake_q.size()), 64'd0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule